// File: doc/BRIEF.md
# Debug Address Translation Request Port

This block gives software a way to ask an address-translation unit to translate one I/O virtual address and to read back the result, without any device traffic. Software writes the address into one 64-bit register and the device and process identifiers into a control register. If it also sets the low control bit, the block issues exactly one request on a valid/ready port toward an external translation engine. The engine does the context lookup and the page-table walk.

When the engine answers, the block packs the answer into a 64-bit response word. A failed translation gives a fault flag plus a cause code. A successful one gives the physical page number. The block then drops the busy bit, so that software polling the control register knows the response can be read. A capability word tells software that this debug facility is present.

The register port is a simple write strobe with an address and data, plus a combinational read-data output for the same address.

Top module: `dbg_xlate_port`

## Requirements
- R1: Register offsets: capability at 0x000, request address at 0x258, request control at 0x260, response at 0x268. The capability word reads exactly bit 31 set, and writes do not change it. Any other offset reads 0.
- R2: After reset the request address reads 0, the control register reads 0x1 (busy bit set, all fields zero) and the response reads 0.
- R3: In the control register, bit 0 is go/busy, bits 31:12 are the process ID and bits 63:40 are the device ID. All other control bits read 0.
- R4: A control write with bit 0 clear stores the ID fields, makes bit 0 read 0 and issues no engine request.
- R5: A control write with bit 0 set, while no request is outstanding, issues exactly one engine request. The request carries the stored address, device ID and process ID, and it stays valid with stable fields until the engine accepts it.
- R6: On success the response word is the physical address bits 55:12 placed at response bits 53:10. All other bits, including bit 0, are 0.
- R7: On an engine fault the response is bit 0 = 1 with the engine's 10-bit cause at bits 19:10. All other bits are 0.
- R8: When the engine reports that no device context exists, the response is a fault with cause 256 (bit 0 = 1, bits 19:10 = 256). This holds even if the engine's fault flag and cause are also set.
- R9: The response register is updated one cycle before the busy bit clears, so a poller that sees busy = 0 always reads the new response.
- R10: While a request is outstanding, writes to the address and control registers have no effect, and no second request is issued.
- R11: The response register is read-only. Writes to it have no effect.
- R12: An engine response that arrives while no request is outstanding leaves the response register and the busy bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 12 | Register byte offset |
| csr_wdata | input | 64 | Register write data |
| csr_rdata | output | 64 | Read data for csr_addr |
| xl_req_valid | output | 1 | Translation request valid |
| xl_req_ready | input | 1 | Engine accepts request |
| xl_req_iova | output | 64 | Address to translate |
| xl_req_devid | output | 24 | Device ID |
| xl_req_pid | output | 20 | Process ID |
| xl_rsp_valid | input | 1 | Engine answer valid (one cycle) |
| xl_rsp_fault | input | 1 | Engine reports a fault |
| xl_rsp_noctx | input | 1 | No device context found |
| xl_rsp_cause | input | 10 | Fault cause code |
| xl_rsp_paddr | input | 56 | Translated physical address |

## Verification
Requests are run with several address, device and process combinations, each with a different kind of answer:
- ordinary mappings, which show the page number is taken from the right address bits;
- an address with bits set above bit 55 and below bit 12, which shows those bits are dropped;
- an all-zero request, which yields an all-zero response;
- a faulting device, which shows the cause lands at bit 10;
- a device with no context, sent with a decoy fault cause, which shows the fixed cause overrides it.

Every run is polled so that the cycle in which busy falls can be compared with the cycle in which the response changes. Further tests cover:
- long engine latency, with register writes attempted in the middle of a request;
- a stray engine answer when no request is outstanding;
- writes to read-only words.

// File: rtl/dbgx_pkg.sv
// Package dbgx_pkg
// Shared offsets, field positions and state type for the debug translation
// request port. Offsets and bit positions are software-visible and fixed.
package dbgx_pkg;
    localparam int          CSR_AW        = 12;
    localparam int          CSR_DW        = 64;
    localparam logic [11:0] OFS_CAP       = 12'h000;
    localparam logic [11:0] OFS_IOVA      = 12'h258;
    localparam logic [11:0] OFS_CTL       = 12'h260;
    localparam logic [11:0] OFS_RSP       = 12'h268;
    localparam int          CAP_DBG_BIT   = 31;
    localparam int          CTL_GO_BIT    = 0;
    localparam int          CTL_PID_LSB   = 12;
    localparam int          CTL_DID_LSB   = 40;
    localparam int          RSP_FLD_LSB   = 10;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2,
        SQ_DONE  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dbgx_csr.sv
// Module dbgx_csr
// Register decode for the debug translation port: stores the request address
// and ID fields, keeps the go/busy bit, drives read data and raises a launch
// pulse. Assumes the sequencer reports 'pending' from launch until the cycle
// in which it pulses 'done'; writes to the request words are dropped meanwhile.
module dbgx_csr
    import dbgx_pkg::*;
#(
    parameter int DID_W = 24,
    parameter int PID_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CSR_AW-1:0] addr,
    input  logic [CSR_DW-1:0] wdata,
    input  logic              pending,
    input  logic              done,
    input  logic [CSR_DW-1:0] resp_word,
    output logic [CSR_DW-1:0] rdata,
    output logic [CSR_DW-1:0] iova_q,
    output logic [DID_W-1:0]  devid_q,
    output logic [PID_W-1:0]  pid_q,
    output logic              launch
);
    logic busy_q;
    logic wr_iova;
    logic wr_ctl;

    // Accept writes to the request words only while idle.
    assign wr_iova = wr && (addr == OFS_IOVA) && !pending;
    assign wr_ctl  = wr && (addr == OFS_CTL)  && !pending;
    assign launch  = wr_ctl && wdata[CTL_GO_BIT];

    // Hold the request address and ID fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iova_q  <= '0;
            devid_q <= '0;
            pid_q   <= '0;
        end else begin
            if (wr_iova) iova_q <= wdata;
            if (wr_ctl) begin
                devid_q <= wdata[CTL_DID_LSB +: DID_W];
                pid_q   <= wdata[CTL_PID_LSB +: PID_W];
            end
        end
    end

    // Go/busy bit: set at reset, follows software when idle, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_q <= 1'b1;
        else if (wr_ctl) busy_q <= wdata[CTL_GO_BIT];
        else if (done)   busy_q <= 1'b0;
    end

    // Read-data multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CAP:  rdata[CAP_DBG_BIT] = 1'b1;
            OFS_IOVA: rdata = iova_q;
            OFS_CTL: begin
                rdata[CTL_GO_BIT]               = busy_q;
                rdata[CTL_PID_LSB +: PID_W]     = pid_q;
                rdata[CTL_DID_LSB +: DID_W]     = devid_q;
            end
            OFS_RSP:  rdata = resp_word;
            default:  rdata = '0;
        endcase
    end

    assert_iova_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> $stable(iova_q));
    assert_ids_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> ($stable(devid_q) && $stable(pid_q)));
    assert_busy_on_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy_q);
    assert_busy_until_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && pending && !done) |=> busy_q);
endmodule

// File: rtl/dbgx_seq.sv
// Module dbgx_seq
// Single-request sequencer: issues one valid/ready request on launch, waits for
// the engine's one-cycle answer, loads the response word, and then reports done
// one cycle later. Assumes the engine answers only after it has accepted a request.
module dbgx_seq
    import dbgx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic req_ready,
    input  logic rsp_valid,
    output logic req_valid,
    output logic pending,
    output logic resp_load,
    output logic done
);
    seq_state_e state_q;
    seq_state_e state_d;

    // Next-state selection for the request life cycle.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_IDLE:  if (launch)    state_d = SQ_ISSUE;
            SQ_ISSUE: if (req_ready) state_d = SQ_WAIT;
            SQ_WAIT:  if (rsp_valid) state_d = SQ_DONE;
            SQ_DONE:                 state_d = SQ_IDLE;
            default:                 state_d = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    assign req_valid = (state_q == SQ_ISSUE);
    assign pending   = (state_q != SQ_IDLE);
    assign resp_load = (state_q == SQ_WAIT) && rsp_valid;
    assign done      = (state_q == SQ_DONE);

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> req_valid);
    assert_single_launch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !pending);
    assert_done_after_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pending) |-> $past(resp_load, 2));
    assert_load_then_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_load |=> done);
endmodule

// File: rtl/dbgx_fmt.sv
// Module dbgx_fmt
// Response formatter and register. A missing context forces the fixed cause.
// Otherwise a fault gives flag plus engine cause, and success gives the page
// number of the physical address. Assumes PA_W - PAGE_SHIFT bits fit above bit 10.
module dbgx_fmt
    import dbgx_pkg::*;
#(
    parameter int PA_W        = 56,
    parameter int CAUSE_W     = 10,
    parameter int PAGE_SHIFT  = 12,
    parameter int NOCTX_CAUSE = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               fault,
    input  logic               noctx,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [PA_W-1:0]    paddr,
    output logic [CSR_DW-1:0]  resp_q
);
    localparam int PPN_W    = PA_W - PAGE_SHIFT;
    localparam int PPN_TOP  = RSP_FLD_LSB + PPN_W;
    localparam logic [CAUSE_W-1:0] NOCTX_CODE = CAUSE_W'(NOCTX_CAUSE);

    logic [CSR_DW-1:0] resp_d;

    // Build the response word from the engine answer.
    always_comb begin
        resp_d = '0;
        if (noctx) begin
            resp_d[0]                      = 1'b1;
            resp_d[RSP_FLD_LSB +: CAUSE_W] = NOCTX_CODE;
        end else if (fault) begin
            resp_d[0]                      = 1'b1;
            resp_d[RSP_FLD_LSB +: CAUSE_W] = cause;
        end else begin
            resp_d[RSP_FLD_LSB +: PPN_W]   = paddr[PA_W-1:PAGE_SHIFT];
        end
    end

    // Response register, loaded only on an accepted engine answer.
    always_ff @(posedge clk) begin
        if (!rst_n)    resp_q <= '0;
        else if (load) resp_q <= resp_d;
    end

    assert_fault_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (fault || noctx)) |=> resp_q[0]);
    assert_noctx_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (load && noctx) |=> (resp_q[RSP_FLD_LSB +: CAUSE_W] == NOCTX_CODE));
    assert_ok_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !fault && !noctx) |=>
            (resp_q[RSP_FLD_LSB-1:0] == '0 && resp_q[CSR_DW-1:PPN_TOP] == '0));
    assert_resp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(resp_q));
endmodule

// File: rtl/dbg_xlate_port.sv
// Module dbg_xlate_port
// Top of the debug translation request port: register decode, request
// sequencer and response formatter. Assumes a single register master and an
// engine that answers every accepted request exactly once.
module dbg_xlate_port
    import dbgx_pkg::*;
#(
    parameter int DID_W       = 24,
    parameter int PID_W       = 20,
    parameter int PA_W        = 56,
    parameter int CAUSE_W     = 10,
    parameter int PAGE_SHIFT  = 12,
    parameter int NOCTX_CAUSE = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_wr,
    input  logic [11:0]        csr_addr,
    input  logic [63:0]        csr_wdata,
    output logic [63:0]        csr_rdata,
    output logic               xl_req_valid,
    input  logic               xl_req_ready,
    output logic [63:0]        xl_req_iova,
    output logic [DID_W-1:0]   xl_req_devid,
    output logic [PID_W-1:0]   xl_req_pid,
    input  logic               xl_rsp_valid,
    input  logic               xl_rsp_fault,
    input  logic               xl_rsp_noctx,
    input  logic [CAUSE_W-1:0] xl_rsp_cause,
    input  logic [PA_W-1:0]    xl_rsp_paddr
);
    logic              pending;
    logic              done;
    logic              launch;
    logic              resp_load;
    logic [CSR_DW-1:0] resp_word;

    dbgx_csr #(.DID_W(DID_W), .PID_W(PID_W)) u_csr (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (csr_wr),
        .addr      (csr_addr),
        .wdata     (csr_wdata),
        .pending   (pending),
        .done      (done),
        .resp_word (resp_word),
        .rdata     (csr_rdata),
        .iova_q    (xl_req_iova),
        .devid_q   (xl_req_devid),
        .pid_q     (xl_req_pid),
        .launch    (launch)
    );

    dbgx_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .req_ready (xl_req_ready),
        .rsp_valid (xl_rsp_valid),
        .req_valid (xl_req_valid),
        .pending   (pending),
        .resp_load (resp_load),
        .done      (done)
    );

    dbgx_fmt #(
        .PA_W(PA_W), .CAUSE_W(CAUSE_W), .PAGE_SHIFT(PAGE_SHIFT), .NOCTX_CAUSE(NOCTX_CAUSE)
    ) u_fmt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (resp_load),
        .fault  (xl_rsp_fault),
        .noctx  (xl_rsp_noctx),
        .cause  (xl_rsp_cause),
        .paddr  (xl_rsp_paddr),
        .resp_q (resp_word)
    );

    assert_req_fields_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req_valid && !xl_req_ready) |=>
            ($stable(xl_req_iova) && $stable(xl_req_devid) && $stable(xl_req_pid)));
endmodule

// File: tb/dbg_xlate_port_bench.sv
// Bench for dbg_xlate_port: a behavioural engine stub, a vector table walked by
// one loop, and directed tests for reset, field layout and corner cases.
module dbg_xlate_port_bench;
    localparam logic [11:0] A_CAP = 12'h000, A_IOVA = 12'h258,
                            A_CTL = 12'h260, A_RSP = 12'h268;
    localparam int NV = 6;
    localparam logic [63:0] V_IOVA [NV] = '{64'h0000_1234_5678_9ABC, 64'h00FF_FFFF_FFFF_F000,
        64'hFFFF_0000_0000_0FFF, 64'h0000_0000_0040_0000, 64'h0000_0000_0000_1000, 64'h0};
    localparam logic [23:0] V_DID [NV] = '{24'h000123, 24'h000001, 24'h0ABCDE,
        24'h00F00D, 24'hE00002, 24'h000000};
    localparam logic [19:0] V_PID [NV] = '{20'h00042, 20'h00000, 20'hFFFFF,
        20'h00001, 20'h00002, 20'h00000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] csr_rdata;
    logic        xl_req_valid;
    logic        xl_req_ready = 1'b0;
    logic [63:0] xl_req_iova;
    logic [23:0] xl_req_devid;
    logic [19:0] xl_req_pid;
    logic        xl_rsp_valid = 1'b0;
    logic        xl_rsp_fault = 1'b0;
    logic        xl_rsp_noctx = 1'b0;
    logic [9:0]  xl_rsp_cause = '0;
    logic [55:0] xl_rsp_paddr = '0;

    int total = 0;
    int bad = 0;
    int req_count = 0;
    int lat_cfg = 2;
    int spur_cnt = 0;
    int spur_done = 0;
    logic [63:0] cap_iova;
    logic [23:0] cap_did;
    logic [19:0] cap_pid;

    always #5 clk = ~clk;

    dbg_xlate_port u_dbg_xlate_port (.*);

    // Stub mapping: device 0x00F00D faults with cause 13; devices 0xExxxxx have
    // no context (decoy fault, cause 7); the rest map iova ^ {did[11:0], pid, 24'h0}.
    function automatic logic [55:0] map_pa(input logic [63:0] iova, input logic [23:0] did,
                                           input logic [19:0] pid);
        return iova[55:0] ^ {did[11:0], pid, 24'h0};
    endfunction

    function automatic logic [63:0] exp_rsp(input logic [63:0] iova, input logic [23:0] did,
                                            input logic [19:0] pid);
        logic [55:0] pa;
        if (did[23:20] == 4'hE)  return 64'h1 | (64'd256 << 10);
        if (did == 24'h00F00D)   return 64'h1 | (64'd13 << 10);
        pa = map_pa(iova, did, pid);
        return {10'h0, pa[55:12], 10'h0};
    endfunction

    function automatic logic [63:0] ctl_word(input logic [23:0] did, input logic [19:0] pid,
                                             input logic go);
        return {did, 8'h0, pid, 11'h0, go};
    endfunction

    // Behavioural translation engine with toggling ready and configurable latency.
    logic stub_busy = 1'b0;
    int   stub_cnt = 0;
    always @(posedge clk) begin
        xl_req_ready <= ~xl_req_ready;
        xl_rsp_valid <= 1'b0;
        if (spur_done != spur_cnt) begin
            spur_done    <= spur_cnt;
            xl_rsp_valid <= 1'b1;
            xl_rsp_fault <= 1'b1;
            xl_rsp_noctx <= 1'b0;
            xl_rsp_cause <= 10'd3;
            xl_rsp_paddr <= '1;
        end else if (!stub_busy && xl_req_valid && xl_req_ready) begin
            stub_busy <= 1'b1;
            stub_cnt  <= lat_cfg;
            req_count <= req_count + 1;
            cap_iova  <= xl_req_iova;
            cap_did   <= xl_req_devid;
            cap_pid   <= xl_req_pid;
        end else if (stub_busy) begin
            if (stub_cnt == 0) begin
                stub_busy    <= 1'b0;
                xl_rsp_valid <= 1'b1;
                xl_rsp_noctx <= (cap_did[23:20] == 4'hE);
                xl_rsp_fault <= (cap_did == 24'h00F00D) || (cap_did[23:20] == 4'hE);
                xl_rsp_cause <= (cap_did[23:20] == 4'hE) ? 10'd7 : 10'd13;
                xl_rsp_paddr <= map_pa(cap_iova, cap_did, cap_pid);
            end else begin
                stub_cnt <= stub_cnt - 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [63:0] d);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [63:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    // Poll at each falling edge until busy reads 0; check the response was already
    // final in the cycle before busy fell (R9) and is the expected word.
    task automatic wait_done(input string tag, input logic [63:0] exp);
        logic [63:0] r, c, prev_r;
        prev_r = '0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            bus_read(A_RSP, r);
            bus_read(A_CTL, c);
            if (c[0] == 1'b0) begin
                chk("R9 response final before busy cleared", prev_r, exp);
                chk(tag, r, exp);
                return;
            end
            prev_r = r;
        end
        chk("R9 busy never cleared", 64'h1, 64'h0);
    endtask

    initial begin
        #1_500_000;
        bad++; total++;
        $display("FAIL R5 watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] r;
        int n0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset values; R1: capability word
        bus_read(A_IOVA, r); chk("R2 iova after reset", r, 64'h0);
        bus_read(A_CTL, r);  chk("R2 control after reset", r, 64'h1);
        bus_read(A_RSP, r);  chk("R2 response after reset", r, 64'h0);
        bus_read(A_CAP, r);  chk("R1 capability word", r, 64'h8000_0000);

        // R4: control write with go clear issues nothing and stores fields
        bus_write(A_CTL, ctl_word(24'h123456, 20'hABCDE, 1'b0));
        repeat (6) @(negedge clk);
        chk("R4 no request issued", 64'(req_count), 64'd0);
        bus_read(A_CTL, r);  chk("R4 fields stored, go reads 0", r, ctl_word(24'h123456, 20'hABCDE, 1'b0));

        // R3: reserved control bits read 0
        bus_write(A_CTL, ~64'h1);
        bus_read(A_CTL, r);  chk("R3 control field mask", r, ctl_word(24'hFFFFFF, 20'hFFFFF, 1'b0));

        // R1: capability and unknown offsets ignore writes
        bus_write(A_CAP, 64'h0);
        bus_read(A_CAP, r);  chk("R1 capability unchanged by write", r, 64'h8000_0000);
        bus_read(12'h100, r); chk("R1 unmapped offset reads 0", r, 64'h0);

        // R5..R9: vector table
        for (int v = 0; v < NV; v++) begin
            n0 = req_count;
            bus_write(A_IOVA, V_IOVA[v]);
            bus_write(A_CTL, ctl_word(V_DID[v], V_PID[v], 1'b1));
            wait_done((V_DID[v][23:20] == 4'hE) ? "R8 no-context response" :
                      (V_DID[v] == 24'h00F00D) ? "R7 fault response" : "R6 page number response",
                      exp_rsp(V_IOVA[v], V_DID[v], V_PID[v]));
            chk("R5 one request per go", 64'(req_count - n0), 64'd1);
            chk("R5 request address", cap_iova, V_IOVA[v]);
            chk("R5 request device/process", {16'h0, cap_did, cap_pid}, {16'h0, V_DID[v], V_PID[v]});
        end

        // R11: response is read-only
        bus_read(A_RSP, r);
        bus_write(A_RSP, ~r);
        bus_read(A_RSP, csr_wdata); chk("R11 response write ignored", csr_wdata, r);

        // R10: writes during an outstanding request are dropped
        lat_cfg = 30;
        n0 = req_count;
        bus_write(A_IOVA, 64'h0000_0000_0007_7000);
        bus_write(A_CTL, ctl_word(24'h000055, 20'h00033, 1'b1));
        bus_write(A_IOVA, 64'hDEAD_BEEF_0000_0000);
        bus_write(A_CTL, ctl_word(24'h0000AA, 20'h00011, 1'b1));
        wait_done("R10 response of first request", exp_rsp(64'h7_7000, 24'h000055, 20'h00033));
        repeat (40) @(negedge clk);
        chk("R10 single request issued", 64'(req_count - n0), 64'd1);
        bus_read(A_IOVA, r); chk("R10 iova write ignored while busy", r, 64'h0000_0000_0007_7000);
        bus_read(A_CTL, r);  chk("R10 control write ignored while busy", r, ctl_word(24'h000055, 20'h00033, 1'b0));

        // R12: stray engine answer when idle
        bus_read(A_RSP, r);
        @(negedge clk); spur_cnt++;
        repeat (4) @(negedge clk);
        bus_read(A_RSP, csr_wdata); chk("R12 stray answer ignored", csr_wdata, r);
        bus_read(A_CTL, csr_wdata); chk("R12 busy stays clear", {63'h0, csr_wdata[0]}, 64'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule